// File: doc/BRIEF.md
# Longest-Prefix Winner Selector

This block takes one search result per cycle from a table of prefix entries: a match bit for every entry and the prefix length stored with that entry. It reports whether any entry matched, the length of the longest matching prefix, and the index of the entry that holds it. The index then addresses next-hop data kept elsewhere. Entries may sit in the table in any order, because the block ranks them by length and not by position.

The maximum is not found with magnitude comparators. Each pipeline stage looks at one bit of the length code, starting at the most significant bit, and holds a mask of the entries still in the running. If any entry in the mask has the stage's bit set, the entries with that bit clear leave the mask. If none has it set, the mask passes on unchanged. After the last bit stage, the entries left in the mask all share the maximum length, and an encoder picks the one with the lowest index.

The table is cut into sections of equal size. Each section has its own copy of the selector, and all copies run in parallel. The section winners then enter one more copy of the same selector, which picks the global winner. Each selector instance takes LEN_W + 1 cycles, so the whole block takes 2·(LEN_W + 1) cycles and accepts a new search every cycle.

Top module: `lpm_tree`

## Requirements
- R1: `valid_o` reproduces `valid_i` delayed by exactly 2·(LEN_W+1) clock cycles. All other outputs in that cycle belong to the same search.
- R2: `hit_o` is 1 exactly when the search was valid and at least one `match_i` bit was set. On a miss, `idx_o` and `len_o` are both 0.
- R3: On a hit, `len_o` equals the largest length among the matched entries.
- R4: On a hit, `idx_o` names a matched entry of maximum length. When several matched entries share that length, it names the lowest-indexed one.
- R5: The lengths of entries whose match bit is 0 do not affect any output, even when they exceed every matched length.
- R6: Entry i (i = section·N_LOC + local position) uses match bit `match_i[i]` and length field `len_i[i*LEN_W +: LEN_W]`. `idx_o` reports i in binary.
- R7: Searches can be presented on back-to-back cycles. Results come out in input order, one per cycle, with no stall.
- R8: A cycle with `valid_i` = 0 yields `valid_o` = 0, `hit_o` = 0, `idx_o` = 0 and `len_o` = 0 after the latency of R1, whatever the match bits were.
- R9: A matched entry of length 0 is a valid winner. If all matched lengths are 0, `hit_o` = 1, `len_o` = 0, and `idx_o` is the lowest matched index.
- R10: While `rst_ni` is low and until the first search arrives, `valid_o`, `hit_o`, `idx_o` and `len_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A search result is present this cycle |
| match_i | input | N_SEC·N_LOC | Match bit per entry |
| len_i | input | N_SEC·N_LOC·LEN_W | Prefix length per entry, packed by entry index |
| valid_o | output | 1 | Delayed `valid_i` |
| hit_o | output | 1 | At least one entry matched |
| idx_o | output | clog2(N_SEC·N_LOC) | Index of the winning entry |
| len_o | output | LEN_W | Length of the winning entry |

## Verification
The bench builds the block with two sections of four entries and 3-bit lengths. This gives an 8-cycle pipeline and makes all 256 match patterns reachable, and it sweeps through those patterns four times. Each pass uses a different way of choosing lengths: free random, pairs of tied near-maximum values, identical values that include zero, and unmatched entries loaded with the top length. Together these reach the tie-break, zero-length and ignore rules in every section, at both tiers. Invalid cycles are mixed into the stream at regular intervals.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned DEF_N_SEC = 4;
  localparam int unsigned DEF_N_LOC = 8;
  localparam int unsigned DEF_LEN_W = 7;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/lpm_level.sv
module lpm_level #(
  parameter int unsigned N     = 8,
  parameter int unsigned LEN_W = 7,
  parameter int unsigned TAG_W = 3,
  parameter int unsigned BIT   = 0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [N-1:0]                mask_i,
  input  logic [N-1:0][LEN_W-1:0]     len_i,
  input  logic [N-1:0][TAG_W-1:0]     tag_i,
  output logic                        valid_o,
  output logic [N-1:0]                mask_o,
  output logic [N-1:0][LEN_W-1:0]     len_o,
  output logic [N-1:0][TAG_W-1:0]     tag_o
);
  logic [N-1:0] bit_set, cand, keep;

  always_comb begin
    for (int i = 0; i < N; i++) bit_set[i] = len_i[i][BIT];
    cand = mask_i & bit_set;
    // drop survivors lacking this bit only if some survivor has it
    keep = (|cand) ? cand : mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mask_o  <= '0;
      len_o   <= '0;
      tag_o   <= '0;
    end else begin
      valid_o <= valid_i;
      mask_o  <= keep;
      len_o   <= len_i;
      tag_o   <= tag_i;
    end
  end
endmodule

// File: rtl/lpm_enc.sv
module lpm_enc #(
  parameter int unsigned N     = 8,
  parameter int unsigned LEN_W = 7,
  parameter int unsigned TAG_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [N-1:0]                mask_i,
  input  logic [N-1:0][LEN_W-1:0]     len_i,
  input  logic [N-1:0][TAG_W-1:0]     tag_i,
  output logic                        valid_o,
  output logic                        hit_o,
  output logic [LEN_W-1:0]            len_o,
  output logic [TAG_W-1:0]            tag_o
);
  logic             found;
  logic [LEN_W-1:0] len_d;
  logic [TAG_W-1:0] tag_d;

  always_comb begin
    found = 1'b0;
    len_d = '0;
    tag_d = '0;
    for (int i = 0; i < N; i++) begin
      if (mask_i[i] && !found) begin
        found = 1'b1;
        len_d = len_i[i];
        tag_d = tag_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      hit_o   <= 1'b0;
      len_o   <= '0;
      tag_o   <= '0;
    end else begin
      valid_o <= valid_i;
      hit_o   <= found;
      len_o   <= len_d;
      tag_o   <= tag_d;
    end
  end
endmodule

// File: rtl/lpm_sel.sv
module lpm_sel #(
  parameter int unsigned N     = 8,
  parameter int unsigned LEN_W = 7,
  parameter int unsigned TAG_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [N-1:0]                match_i,
  input  logic [N-1:0][LEN_W-1:0]     len_i,
  input  logic [N-1:0][TAG_W-1:0]     tag_i,
  output logic                        valid_o,
  output logic                        hit_o,
  output logic [LEN_W-1:0]            len_o,
  output logic [TAG_W-1:0]            tag_o
);
  localparam int unsigned STAGES = LEN_W + 1;

  logic                    v_s [STAGES];
  logic [N-1:0]            m_s [STAGES];
  logic [N-1:0][LEN_W-1:0] l_s [STAGES];
  logic [N-1:0][TAG_W-1:0] t_s [STAGES];

  assign v_s[0] = valid_i;
  assign m_s[0] = match_i & {N{valid_i}};
  assign l_s[0] = len_i;
  assign t_s[0] = tag_i;

  for (genvar k = 0; k < LEN_W; k++) begin : g_lvl
    lpm_level #(
      .N(N), .LEN_W(LEN_W), .TAG_W(TAG_W), .BIT(LEN_W - 1 - k)
    ) u_lvl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (v_s[k]),
      .mask_i  (m_s[k]),
      .len_i   (l_s[k]),
      .tag_i   (t_s[k]),
      .valid_o (v_s[k+1]),
      .mask_o  (m_s[k+1]),
      .len_o   (l_s[k+1]),
      .tag_o   (t_s[k+1])
    );
  end

  lpm_enc #(.N(N), .LEN_W(LEN_W), .TAG_W(TAG_W)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (v_s[LEN_W]),
    .mask_i  (m_s[LEN_W]),
    .len_i   (l_s[LEN_W]),
    .tag_i   (t_s[LEN_W]),
    .valid_o (valid_o),
    .hit_o   (hit_o),
    .len_o   (len_o),
    .tag_o   (tag_o)
  );
endmodule

// File: rtl/lpm_tree.sv
module lpm_tree
  import lpm_pkg::*;
#(
  parameter  int unsigned N_SEC  = DEF_N_SEC,
  parameter  int unsigned N_LOC  = DEF_N_LOC,
  parameter  int unsigned LEN_W  = DEF_LEN_W,
  localparam int unsigned N_CAND = N_SEC * N_LOC,
  localparam int unsigned IDX_W  = clog2_min1(N_CAND)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [N_CAND-1:0]         match_i,
  input  logic [N_CAND*LEN_W-1:0]   len_i,
  output logic                      valid_o,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic [LEN_W-1:0]          len_o
);
  localparam int unsigned LOC_W = clog2_min1(N_LOC);

  logic [N_LOC-1:0][LOC_W-1:0] loc_tag;
  logic [N_SEC-1:0]            l_valid, l_hit;
  logic [N_SEC-1:0][LEN_W-1:0] g_len;
  logic [N_SEC-1:0][IDX_W-1:0] g_tag;
  logic [LOC_W-1:0]            l_tag [N_SEC];

  always_comb begin
    for (int i = 0; i < N_LOC; i++) loc_tag[i] = LOC_W'(i);
  end

  for (genvar s = 0; s < N_SEC; s++) begin : g_sec
    logic [N_LOC-1:0][LEN_W-1:0] sec_len;
    assign sec_len = len_i[s*N_LOC*LEN_W +: N_LOC*LEN_W];

    lpm_sel #(.N(N_LOC), .LEN_W(LEN_W), .TAG_W(LOC_W)) u_loc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .match_i (match_i[s*N_LOC +: N_LOC]),
      .len_i   (sec_len),
      .tag_i   (loc_tag),
      .valid_o (l_valid[s]),
      .hit_o   (l_hit[s]),
      .len_o   (g_len[s]),
      .tag_o   (l_tag[s])
    );

    // section base plus local position gives the table index
    assign g_tag[s] = IDX_W'(s * N_LOC) + IDX_W'(l_tag[s]);
  end

  lpm_sel #(.N(N_SEC), .LEN_W(LEN_W), .TAG_W(IDX_W)) u_glob (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (&l_valid),
    .match_i (l_hit),
    .len_i   (g_len),
    .tag_i   (g_tag),
    .valid_o (valid_o),
    .hit_o   (hit_o),
    .len_o   (len_o),
    .tag_o   (idx_o)
  );
endmodule

// File: rtl/lpm_tree_chk.sv
module lpm_tree_chk
  import lpm_pkg::*;
#(
  parameter  int unsigned N_SEC  = DEF_N_SEC,
  parameter  int unsigned N_LOC  = DEF_N_LOC,
  parameter  int unsigned LEN_W  = DEF_LEN_W,
  localparam int unsigned N_CAND = N_SEC * N_LOC,
  localparam int unsigned IDX_W  = clog2_min1(N_CAND)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic [N_CAND-1:0]       match_i,
  input logic [N_CAND*LEN_W-1:0] len_i,
  input logic                    valid_o,
  input logic                    hit_o,
  input logic [IDX_W-1:0]        idx_o,
  input logic [LEN_W-1:0]        len_o
);
  localparam int unsigned LAT = 2 * (LEN_W + 1);

  logic [LAT-1:0]          v_pipe;
  logic [N_CAND-1:0]       m_pipe [LAT];
  logic [N_CAND*LEN_W-1:0] l_pipe [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_pipe <= '0;
      for (int k = 0; k < LAT; k++) begin
        m_pipe[k] <= '0;
        l_pipe[k] <= '0;
      end
    end else begin
      v_pipe    <= {v_pipe[LAT-2:0], valid_i};
      m_pipe[0] <= match_i;
      l_pipe[0] <= len_i;
      for (int k = 1; k < LAT; k++) begin
        m_pipe[k] <= m_pipe[k-1];
        l_pipe[k] <= l_pipe[k-1];
      end
    end
  end

  logic [N_CAND-1:0] m_old;
  logic              longer_seen, lower_tie;

  always_comb begin
    m_old       = v_pipe[LAT-1] ? m_pipe[LAT-1] : '0;
    longer_seen = 1'b0;
    lower_tie   = 1'b0;
    for (int i = 0; i < N_CAND; i++) begin
      if (m_old[i] && (l_pipe[LAT-1][i*LEN_W +: LEN_W] > len_o)) longer_seen = 1'b1;
      if (m_old[i] && (l_pipe[LAT-1][i*LEN_W +: LEN_W] == len_o) && (i < int'(idx_o)))
        lower_tie = 1'b1;
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_pipe[LAT-1]); // R1
  AST_HIT_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o == (|m_old)); // R2
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (idx_o == '0 && len_o == '0)); // R2
  AST_LONGEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !longer_seen); // R3
  AST_LOWEST_TIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !lower_tie); // R4
  AST_WIN_MATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> m_old[idx_o]); // R5
  AST_WIN_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (len_o == l_pipe[LAT-1][idx_o*LEN_W +: LEN_W])); // R6
  AST_HIT_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> valid_o); // R8
endmodule

bind lpm_tree lpm_tree_chk #(.N_SEC(N_SEC), .N_LOC(N_LOC), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/lpm_tree_bench.sv
module lpm_tree_bench;
  localparam int N_SEC = 2;
  localparam int N_LOC = 4;
  localparam int LEN_W = 3;
  localparam int N     = N_SEC * N_LOC;
  localparam int IDX_W = 3;
  localparam int LAT   = 2 * (LEN_W + 1);
  localparam int NCYC  = 4 * 256;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst_ni, valid_i, valid_o, hit_o;
  logic [N-1:0]         match_i;
  logic [N*LEN_W-1:0]   len_i;
  logic [IDX_W-1:0]     idx_o;
  logic [LEN_W-1:0]     len_o;

  lpm_tree #(.N_SEC(N_SEC), .N_LOC(N_LOC), .LEN_W(LEN_W)) u_lpm_tree (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .match_i(match_i),
    .len_i(len_i), .valid_o(valid_o), .hit_o(hit_o), .idx_o(idx_o), .len_o(len_o)
  );

  int checks = 0;
  int fails  = 0;

  logic  ev [16];
  logic  eh [16];
  int    ei [16];
  int    el [16];
  string et [16];

  task automatic check(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int          ph, best, bidx, eq_val, slot;
    logic        h, v;
    logic [2:0]  lv;
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    match_i = '0;
    len_i   = '0;
    for (int k = 0; k < 16; k++) begin
      ev[k] = 1'b0; eh[k] = 1'b0; ei[k] = 0; el[k] = 0; et[k] = "R10";
    end
    repeat (3) @(negedge clk);
    check("R10", "valid_o in reset", int'(valid_o), 0);
    check("R10", "hit_o in reset", int'(hit_o), 0);
    check("R10", "idx_o in reset", int'(idx_o), 0);
    check("R10", "len_o in reset", int'(len_o), 0);
    rst_ni = 1'b1;

    for (int c = 0; c < NCYC + LAT + 2; c++) begin
      @(negedge clk);
      slot = (c + 16 - LAT) % 16;
      check("R1 R7", $sformatf("valid_o c=%0d", c), int'(valid_o), int'(ev[slot]));
      check("R2", $sformatf("hit_o c=%0d %s", c, et[slot]), int'(hit_o), int'(eh[slot]));
      check("R3", $sformatf("len_o c=%0d %s", c, et[slot]), int'(len_o), el[slot]);
      check(et[slot], $sformatf("idx_o c=%0d", c), int'(idx_o), ei[slot]);

      if (c < NCYC) begin
        ph      = c / 256;
        match_i = N'(c % 256);
        v       = ((c % 13) != 5);
        valid_i = v;
        eq_val  = ((c >> 3) ^ c) % 8;
        for (int i = 0; i < N; i++) begin
          case (ph)
            0:       lv = 3'($urandom % 8);
            1:       lv = 3'(6 + ($urandom % 2));
            2:       lv = 3'(eq_val);
            default: lv = match_i[i] ? 3'($urandom % 7) : 3'd7;
          endcase
          len_i[i*LEN_W +: LEN_W] = lv;
        end
        h = 1'b0; best = 0; bidx = 0;
        for (int i = 0; i < N; i++) begin
          if (v && match_i[i] && (!h || int'(len_i[i*LEN_W +: LEN_W]) > best)) begin
            h    = 1'b1;
            best = int'(len_i[i*LEN_W +: LEN_W]);
            bidx = i;
          end
        end
        ev[c % 16] = v;
        eh[c % 16] = h;
        ei[c % 16] = bidx;
        el[c % 16] = best;
        if (!v)          et[c % 16] = "R8";
        else if (ph == 0) et[c % 16] = "R6";
        else if (ph == 1) et[c % 16] = "R4";
        else if (ph == 2) et[c % 16] = "R9";
        else              et[c % 16] = "R5";
      end else begin
        valid_i = 1'b0;
        match_i = '1;
        len_i   = '1;
        ev[c % 16] = 1'b0; eh[c % 16] = 1'b0; ei[c % 16] = 0; el[c % 16] = 0;
        et[c % 16] = "R8";
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule